// File: doc/BRIEF.md
# Escaped Command Stream Decoder for a Video Register File

This block takes a stream of bytes over a valid/ready input and splits it into commands. Each command opens with the escape byte 0xAF and continues with an opcode byte. Two opcodes are understood.

The register-write opcode updates one entry of a 256-entry, 8-bit video register file. A later timing generator reads that file through a read port and through a few decoded fields. The copy opcode is turned into one request on a memory-copy request port. Bytes that cannot start a command and opcodes that are not understood are reported with single-cycle pulses and dropped.

Register writes can be held back by locking the file. While the file is locked, writes go only to a shadow copy. Unlocking moves the whole shadow copy into the active registers in one clock cycle. This lets software change a complete display mode so that the change takes effect all at once.

Top module: `vcmd_stream_decoder`

## Requirements
- R1: After reset the file is unlocked, every active register reads 0, cp_valid and both error pulses are low, and in_ready is high.
- R2: While hunting for a command start, an accepted byte other than 0xAF is discarded and makes sync_err high for exactly one cycle.
- R3: The sequence 0xAF, 0x20, address, data writes data to that register address. Any byte in the address or data position is taken as a value, including 0xAF. While the file is unlocked, the active register holds the new value from the second cycle after the data byte is accepted.
- R4: Writing 0x00 to address 0xFF locks the file. While the file is locked, register writes do not change any active register or decoded output, and vid_locked is high.
- R5: Writing 0xFF to address 0xFF unlocks the file and copies every shadow register into the active file in one cycle. Any other value written to address 0xFF is ignored. Address 0xFF always reads 0.
- R6: The sequence 0xAF, 0x6A, source (3 bytes, most significant first), count (1 byte), destination (3 bytes, most significant first) raises one copy request carrying those three fields.
- R7: A raised copy request keeps cp_valid high and its fields stable until it is accepted with cp_ready. While a request is raised or about to be raised, in_ready is low.
- R8: After 0xAF, an opcode other than 0x20 or 0x6A makes bad_op high for one cycle. The decoder then treats the next byte as a possible command start.
- R9: depth_24 is bit 0 of active register 0x00. blank_code is active register 0x1F. base16 is {reg 0x20, reg 0x21, reg 0x22} and base8 is {reg 0x26, reg 0x27, reg 0x28}, with the most significant byte first in each.
- R10: rd_data shows the active register selected by rd_addr one cycle after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_ready | output | 1 | Decoder can take a byte |
| sync_err | output | 1 | Pulse: byte discarded while hunting for 0xAF |
| bad_op | output | 1 | Pulse: opcode not recognised |
| cp_valid | output | 1 | Copy request valid |
| cp_ready | input | 1 | Copy request accepted |
| cp_src | output | 8*XFER_BYTES | Copy source address |
| cp_dst | output | 8*XFER_BYTES | Copy destination address |
| cp_count | output | 8 | Copy pixel count |
| rd_addr | input | 8 | Active register read address |
| rd_data | output | 8 | Active register read data |
| vid_locked | output | 1 | Register file locked |
| depth_24 | output | 1 | Colour depth select (1 = 24 bits over both planes) |
| blank_code | output | 8 | Output blanking control |
| base16 | output | 24 | Base address of the 16-bit plane |
| base8 | output | 24 | Base address of the 8-bit plane |

## Verification
The bench builds the block with its default XFER_BYTES of 3. With that setting the copy addresses are 24 bits wide, the same width as the two plane base addresses, and a copy command is exactly nine bytes long. The register address space is set by the single address byte, so the bench can read back all 256 entries. That includes the lock address 0xFF and every decoded field. The random stream mixes unlocked writes, locked writes, lock and unlock commands, copies under random backpressure, stray bytes and bad opcodes. Together these reach the shadow-to-active copy with many registers pending at once.

// File: rtl/vcmd_pkg.sv
package vcmd_pkg;
  localparam int          REG_AW      = 8;
  localparam int          REG_N       = 1 << REG_AW;
  localparam int          BASE_W      = 24;
  localparam logic [7:0]  ESC_BYTE    = 8'hAF;
  localparam logic [7:0]  OPC_REGWR   = 8'h20;
  localparam logic [7:0]  OPC_COPY    = 8'h6A;
  localparam logic [7:0]  LOCK_ADDR   = 8'hFF;
  localparam logic [7:0]  LOCK_VAL    = 8'h00;
  localparam logic [7:0]  UNLOCK_VAL  = 8'hFF;
  localparam int          IDX_DEPTH   = 8'h00;
  localparam int          IDX_BLANK   = 8'h1F;
  localparam int          IDX_B16     = 8'h20;
  localparam int          IDX_B8      = 8'h26;
  localparam int          REG_ARGS    = 2;

  typedef enum logic [1:0] {
    PS_HUNT,
    PS_OPCODE,
    PS_ARGS
  } pstate_e;
endpackage

// File: rtl/vcmd_parser.sv
module vcmd_parser
  import vcmd_pkg::*;
#(
  parameter int XFER_BYTES = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    acc,
  input  logic [7:0]              byte_i,
  output logic                    sync_err_o,
  output logic                    bad_op_o,
  output logic                    wr_en_o,
  output logic [REG_AW-1:0]       wr_addr_o,
  output logic [7:0]              wr_data_o,
  output logic                    cp_issue_o,
  output logic [8*XFER_BYTES-1:0] cp_src_o,
  output logic [8*XFER_BYTES-1:0] cp_dst_o,
  output logic [7:0]              cp_cnt_o
);
  localparam int COPY_ARGS = 2 * XFER_BYTES + 1;
  localparam int IW        = $clog2(COPY_ARGS + 1);
  localparam int XW        = 8 * XFER_BYTES;

  pstate_e                      state_q;
  logic                         is_copy_q;
  logic [IW-1:0]                idx_q;
  logic [COPY_ARGS-1:0][7:0]    args_q;
  logic [IW-1:0]                last_idx;
  logic [XW-1:0]                src_c;
  logic [XW-1:0]                dst_c;

  assign last_idx = is_copy_q ? IW'(COPY_ARGS - 1) : IW'(REG_ARGS - 1);

  // Source bytes come first, then the count byte, then the destination bytes.
  // The final destination byte is the one on the bus right now.
  always_comb begin
    for (int b = 0; b < XFER_BYTES; b++) begin
      src_c[(XFER_BYTES-1-b)*8 +: 8] = args_q[b];
    end
    for (int b = 0; b < XFER_BYTES - 1; b++) begin
      dst_c[(XFER_BYTES-1-b)*8 +: 8] = args_q[XFER_BYTES+1+b];
    end
    dst_c[7:0] = byte_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= PS_HUNT;
      is_copy_q  <= 1'b0;
      idx_q      <= '0;
      args_q     <= '0;
      sync_err_o <= 1'b0;
      bad_op_o   <= 1'b0;
      wr_en_o    <= 1'b0;
      wr_addr_o  <= '0;
      wr_data_o  <= '0;
      cp_issue_o <= 1'b0;
      cp_src_o   <= '0;
      cp_dst_o   <= '0;
      cp_cnt_o   <= '0;
    end else begin
      sync_err_o <= 1'b0;
      bad_op_o   <= 1'b0;
      wr_en_o    <= 1'b0;
      cp_issue_o <= 1'b0;
      if (acc) begin
        unique case (state_q)
          PS_HUNT: begin
            if (byte_i == ESC_BYTE) state_q <= PS_OPCODE;
            else                    sync_err_o <= 1'b1;
          end
          PS_OPCODE: begin
            idx_q <= '0;
            if (byte_i == OPC_REGWR) begin
              is_copy_q <= 1'b0;
              state_q   <= PS_ARGS;
            end else if (byte_i == OPC_COPY) begin
              is_copy_q <= 1'b1;
              state_q   <= PS_ARGS;
            end else begin
              bad_op_o <= 1'b1;
              state_q  <= PS_HUNT;
            end
          end
          PS_ARGS: begin
            args_q[idx_q] <= byte_i;
            if (idx_q == last_idx) begin
              state_q <= PS_HUNT;
              if (is_copy_q) begin
                cp_issue_o <= 1'b1;
                cp_src_o   <= src_c;
                cp_dst_o   <= dst_c;
                cp_cnt_o   <= args_q[XFER_BYTES];
              end else begin
                wr_en_o   <= 1'b1;
                wr_addr_o <= args_q[0];
                wr_data_o <= byte_i;
              end
            end else begin
              idx_q <= idx_q + 1'b1;
            end
          end
          default: state_q <= PS_HUNT;
        endcase
      end
    end
  end

  AST_SYNC_NEEDS_BYTE: assert property (@(posedge clk) disable iff (rst)
    sync_err_o |-> $past(acc)); // R2
  AST_ERR_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(sync_err_o && bad_op_o)); // R8
  AST_BADOP_RESYNC: assert property (@(posedge clk) disable iff (rst)
    bad_op_o |-> (state_q == PS_HUNT)); // R8
endmodule

// File: rtl/vcmd_regfile.sv
module vcmd_regfile
  import vcmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [REG_AW-1:0] rd_addr,
  output logic [7:0]        rd_data,
  output logic              locked_o,
  output logic              depth_24,
  output logic [7:0]        blank_code,
  output logic [BASE_W-1:0] base16,
  output logic [BASE_W-1:0] base8
);
  logic [REG_N-1:0][7:0] act_q;
  logic [REG_N-1:0][7:0] sh_q;
  logic                  locked_q;
  logic                  ctl_w;
  logic                  lock_w;
  logic                  unlock_w;
  logic                  data_w;

  assign ctl_w    = wr_en && (wr_addr == LOCK_ADDR);
  assign lock_w   = ctl_w && (wr_data == LOCK_VAL);
  assign unlock_w = ctl_w && (wr_data == UNLOCK_VAL);
  assign data_w   = wr_en && (wr_addr != LOCK_ADDR);

  always_ff @(posedge clk) begin
    if (rst)           locked_q <= 1'b0;
    else if (lock_w)   locked_q <= 1'b1;
    else if (unlock_w) locked_q <= 1'b0;
  end

  for (genvar i = 0; i < REG_N; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        sh_q[i]  <= '0;
        act_q[i] <= '0;
      end else begin
        if (data_w && (wr_addr == REG_AW'(i))) sh_q[i] <= wr_data;
        if (unlock_w)
          act_q[i] <= sh_q[i];
        else if (data_w && !locked_q && (wr_addr == REG_AW'(i)))
          act_q[i] <= wr_data;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= act_q[rd_addr];
  end

  assign locked_o   = locked_q;
  assign depth_24   = act_q[IDX_DEPTH][0];
  assign blank_code = act_q[IDX_BLANK];
  assign base16     = {act_q[IDX_B16], act_q[IDX_B16+1], act_q[IDX_B16+2]};
  assign base8      = {act_q[IDX_B8],  act_q[IDX_B8+1],  act_q[IDX_B8+2]};

  AST_LOCKED_FREEZE: assert property (@(posedge clk) disable iff (rst)
    (locked_q && !unlock_w) |=> $stable(act_q)); // R4
  AST_UNLOCK_COPY: assert property (@(posedge clk) disable iff (rst)
    unlock_w |=> (act_q == $past(sh_q))); // R5
endmodule

// File: rtl/vcmd_copy_port.sv
module vcmd_copy_port #(
  parameter int XFER_BYTES = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    issue,
  input  logic [8*XFER_BYTES-1:0] src_i,
  input  logic [8*XFER_BYTES-1:0] dst_i,
  input  logic [7:0]              cnt_i,
  output logic                    cp_valid,
  input  logic                    cp_ready,
  output logic [8*XFER_BYTES-1:0] cp_src,
  output logic [8*XFER_BYTES-1:0] cp_dst,
  output logic [7:0]              cp_count
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cp_valid <= 1'b0;
      cp_src   <= '0;
      cp_dst   <= '0;
      cp_count <= '0;
    end else if (issue) begin
      cp_valid <= 1'b1;
      cp_src   <= src_i;
      cp_dst   <= dst_i;
      cp_count <= cnt_i;
    end else if (cp_valid && cp_ready) begin
      cp_valid <= 1'b0;
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (cp_valid && !cp_ready) |=> (cp_valid && $stable(cp_src) && $stable(cp_dst)
                                 && $stable(cp_count))); // R7
  AST_NO_OVERRUN: assert property (@(posedge clk) disable iff (rst)
    issue |-> !cp_valid); // R7
endmodule

// File: rtl/vcmd_stream_decoder.sv
module vcmd_stream_decoder
  import vcmd_pkg::*;
#(
  parameter int XFER_BYTES = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic [7:0]              in_data,
  output logic                    in_ready,
  output logic                    sync_err,
  output logic                    bad_op,
  output logic                    cp_valid,
  input  logic                    cp_ready,
  output logic [8*XFER_BYTES-1:0] cp_src,
  output logic [8*XFER_BYTES-1:0] cp_dst,
  output logic [7:0]              cp_count,
  input  logic [7:0]              rd_addr,
  output logic [7:0]              rd_data,
  output logic                    vid_locked,
  output logic                    depth_24,
  output logic [7:0]              blank_code,
  output logic [23:0]             base16,
  output logic [23:0]             base8
);
  localparam int XW = 8 * XFER_BYTES;

  logic              acc;
  logic              wr_en;
  logic [REG_AW-1:0] wr_addr;
  logic [7:0]        wr_data;
  logic              cp_issue;
  logic [XW-1:0]     iss_src;
  logic [XW-1:0]     iss_dst;
  logic [7:0]        iss_cnt;

  // Input stalls while a copy request is being raised or is waiting.
  assign in_ready = !cp_valid && !cp_issue;
  assign acc      = in_valid && in_ready;

  vcmd_parser #(.XFER_BYTES(XFER_BYTES)) parser_i (
    .clk        (clk),
    .rst        (rst),
    .acc        (acc),
    .byte_i     (in_data),
    .sync_err_o (sync_err),
    .bad_op_o   (bad_op),
    .wr_en_o    (wr_en),
    .wr_addr_o  (wr_addr),
    .wr_data_o  (wr_data),
    .cp_issue_o (cp_issue),
    .cp_src_o   (iss_src),
    .cp_dst_o   (iss_dst),
    .cp_cnt_o   (iss_cnt)
  );

  vcmd_regfile regs_i (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .rd_addr    (rd_addr),
    .rd_data    (rd_data),
    .locked_o   (vid_locked),
    .depth_24   (depth_24),
    .blank_code (blank_code),
    .base16     (base16),
    .base8      (base8)
  );

  vcmd_copy_port #(.XFER_BYTES(XFER_BYTES)) copy_i (
    .clk      (clk),
    .rst      (rst),
    .issue    (cp_issue),
    .src_i    (iss_src),
    .dst_i    (iss_dst),
    .cnt_i    (iss_cnt),
    .cp_valid (cp_valid),
    .cp_ready (cp_ready),
    .cp_src   (cp_src),
    .cp_dst   (cp_dst),
    .cp_count (cp_count)
  );

  AST_ACCEPT_ONLY_IDLE: assert property (@(posedge clk) disable iff (rst)
    cp_valid |-> !acc); // R7
endmodule

// File: tb/vcmd_stream_decoder_tb.sv
module vcmd_stream_decoder_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = 8'h00;
  logic        in_ready;
  logic        sync_err, bad_op;
  logic        cp_valid;
  logic        cp_ready = 1'b0;
  logic [23:0] cp_src, cp_dst;
  logic [7:0]  cp_count;
  logic [7:0]  rd_addr = 8'h00;
  logic [7:0]  rd_data;
  logic        vid_locked, depth_24;
  logic [7:0]  blank_code;
  logic [23:0] base16, base8;

  vcmd_stream_decoder dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .sync_err(sync_err), .bad_op(bad_op),
    .cp_valid(cp_valid), .cp_ready(cp_ready), .cp_src(cp_src),
    .cp_dst(cp_dst), .cp_count(cp_count), .rd_addr(rd_addr),
    .rd_data(rd_data), .vid_locked(vid_locked), .depth_24(depth_24),
    .blank_code(blank_code), .base16(base16), .base8(base8)
  );

  always #2 clk = ~clk;   // 250 MHz

  int vectors = 0;
  int miscompares = 0;
  bit reported = 0;

  logic [7:0]  m_act [256];
  logic [7:0]  m_sh  [256];
  bit          m_lock = 0;
  int          exp_sync = 0, exp_bad = 0;
  int          seen_sync = 0, seen_bad = 0;
  logic [55:0] cp_exp [1024];
  int          cp_exp_n = 0, cp_obs = 0;
  int          rdy_mode = 0;   // 0 random, 1 low, 2 high

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!reported) begin
      reported = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  function automatic logic [23:0] exp_base(int lo);
    return {m_act[lo], m_act[lo+1], m_act[lo+2]};
  endfunction

  // Drivers act 1 ns after the rising edge; monitors sample at the falling edge.
  always @(posedge clk) begin
    #1;
    if (rdy_mode == 1)      cp_ready = 1'b0;
    else if (rdy_mode == 2) cp_ready = 1'b1;
    else                    cp_ready = ($urandom % 3) == 0;
  end

  always @(negedge clk) begin
    if (!rst) begin
      if (sync_err) seen_sync++;
      if (bad_op)   seen_bad++;
      if (cp_valid && cp_ready) begin
        if (cp_obs < cp_exp_n) chk("R6 copy fields", {cp_src, cp_count, cp_dst}, cp_exp[cp_obs]);
        else                   chk("R6 unexpected copy", 1, 0);
        cp_obs++;
      end
    end
  end

  task automatic send_byte(logic [7:0] b);
    @(posedge clk); #1;
    in_valid = 1'b1; in_data = b;
    forever begin
      @(negedge clk);
      if (in_ready) begin
        @(posedge clk); #1;
        in_valid = 1'b0;
        break;
      end
      @(posedge clk);
    end
  endtask

  task automatic wr_reg(logic [7:0] a, logic [7:0] d);
    send_byte(8'hAF); send_byte(8'h20); send_byte(a); send_byte(d);
    if (a == 8'hFF) begin
      if (d == 8'h00) m_lock = 1;
      else if (d == 8'hFF) begin
        m_lock = 0;
        for (int i = 0; i < 256; i++) m_act[i] = m_sh[i];
      end
    end else begin
      m_sh[a] = d;
      if (!m_lock) m_act[a] = d;
    end
  endtask

  task automatic copy_cmd(logic [23:0] s, logic [7:0] n, logic [23:0] d);
    cp_exp[cp_exp_n] = {s, n, d};
    cp_exp_n++;
    send_byte(8'hAF); send_byte(8'h6A);
    send_byte(s[23:16]); send_byte(s[15:8]); send_byte(s[7:0]);
    send_byte(n);
    send_byte(d[23:16]); send_byte(d[15:8]); send_byte(d[7:0]);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  task automatic rd(logic [7:0] a, output logic [7:0] v);
    @(posedge clk); #1 rd_addr = a;
    @(negedge clk);   // rd_data has the address sampled at the edge before
    @(posedge clk);
    @(negedge clk) v = rd_data;
  endtask

  initial begin
    #(4ns * 200000);
    miscompares++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < 256; i++) begin m_act[i] = 8'h00; m_sh[i] = 8'h00; end
    rdy_mode = 2;
    idle(4);
    @(negedge clk);
    chk("R1 in_ready", in_ready, 1);
    chk("R1 cp_valid", cp_valid, 0);
    chk("R1 locked", vid_locked, 0);
    chk("R1 sync_err", sync_err, 0);
    @(posedge clk); #1 rst = 1'b0;
    rd(8'h1F, v); chk("R1 reg 1F", v, 0);

    // unlocked write, including a data byte of 0xAF
    wr_reg(8'h1F, 8'h05); idle(2);
    chk("R9 blank_code", blank_code, 8'h05);
    rd(8'h1F, v); chk("R10 read 1F", v, 8'h05);
    wr_reg(8'h40, 8'hAF); rd(8'h40, v); chk("R3 data AF", v, 8'hAF);

    // locked writes are held in shadow
    wr_reg(8'hFF, 8'h00); idle(2);
    chk("R4 locked", vid_locked, 1);
    wr_reg(8'h00, 8'h01); wr_reg(8'h20, 8'h12); wr_reg(8'h21, 8'h34); wr_reg(8'h22, 8'h56);
    wr_reg(8'h26, 8'hAB); wr_reg(8'h27, 8'hCD); wr_reg(8'h28, 8'hEF);
    idle(2);
    chk("R4 depth frozen", depth_24, 0);
    chk("R4 base16 frozen", base16, 0);
    rd(8'h00, v); chk("R4 reg 00 frozen", v, 0);
    wr_reg(8'hFF, 8'h42); idle(2);
    chk("R5 other value ignored", vid_locked, 1);
    rd(8'hFF, v); chk("R5 FF reads 0", v, 0);
    wr_reg(8'hFF, 8'hFF); idle(2);
    chk("R5 unlocked", vid_locked, 0);
    chk("R5 R9 depth", depth_24, 1);
    chk("R9 base16", base16, 24'h123456);
    chk("R9 base8", base8, 24'hABCDEF);

    // sync error and bad opcode recovery
    send_byte(8'h13); exp_sync++;
    send_byte(8'hAF); send_byte(8'h55); exp_bad++;
    wr_reg(8'h41, 8'h99); idle(2);
    chk("R2 sync count", seen_sync, exp_sync);
    chk("R8 bad count", seen_bad, exp_bad);
    rd(8'h41, v); chk("R8 resync write", v, 8'h99);

    // copy under held backpressure
    rdy_mode = 1;
    copy_cmd(24'h010203, 8'h01, 24'hA0B0C0);
    idle(3);
    @(negedge clk);
    chk("R7 valid held", cp_valid, 1);
    chk("R7 in_ready low", in_ready, 0);
    chk("R6 src shown", cp_src, 24'h010203);
    idle(4);
    @(negedge clk);
    chk("R7 still held", cp_valid, 1);
    rdy_mode = 2;
    idle(3);
    chk("R6 copy taken", cp_obs, 1);

    // constrained random stream
    rdy_mode = 0;
    for (int k = 0; k < 400; k++) begin
      int sel = $urandom % 20;
      if (sel < 10) begin
        logic [7:0] a = $urandom;
        if (a == 8'hFF) a = 8'h7E;
        wr_reg(a, $urandom);
      end else if (sel == 10) wr_reg(8'hFF, 8'h00);
      else if (sel == 11) wr_reg(8'hFF, 8'hFF);
      else if (sel == 12) wr_reg(8'hFF, 8'h5A);
      else if (sel < 16) copy_cmd($urandom, $urandom, $urandom);
      else if (sel < 18) begin
        logic [7:0] g = $urandom;
        if (g == 8'hAF) g = 8'h00;
        send_byte(g); exp_sync++;
      end else begin
        logic [7:0] o = $urandom;
        if (o == 8'h20 || o == 8'h6A) o = o ^ 8'h01;
        send_byte(8'hAF); send_byte(o); exp_bad++;
      end
    end
    rdy_mode = 2;
    idle(6);
    chk("R6 copy total", cp_obs, cp_exp_n);
    chk("R2 sync total", seen_sync, exp_sync);
    chk("R8 bad total", seen_bad, exp_bad);
    chk("R4 lock state", vid_locked, m_lock);
    chk("R9 depth", depth_24, m_act[0][0]);
    chk("R9 blank", blank_code, m_act[8'h1F]);
    chk("R9 base16 rand", base16, exp_base(8'h20));
    chk("R9 base8 rand", base8, exp_base(8'h26));
    for (int i = 0; i < 256; i++) begin
      rd(i[7:0], v);
      chk("R3 R10 active file", {i[7:0], v}, {i[7:0], m_act[i]});
    end
    if (!m_lock) begin
      wr_reg(8'hFF, 8'h00);
      wr_reg(8'h05, 8'h3C);
    end
    wr_reg(8'hFF, 8'hFF);
    for (int i = 0; i < 8; i++) begin
      rd(i[7:0], v);
      chk("R5 shadow copied", v, m_act[i]);
    end
    summary();
  end
endmodule